// File: doc/BRIEF.md
# Mode-Selectable Clock Enable Generator

This block derives a family of single-cycle enable strobes from one core clock, for the timer, PWM, SPI and UART parts of a small system. It generates no clocks. Each output is a clock enable in the core domain, and consumers qualify their own flops with it. A mode input tells the block what the core clock is. Mode 0 treats it as a CPU clock taken from a PLL. Mode 1 treats it as a fixed external clock. The division ratios of every reference follow that mode.

A small write-only control register holds two settings. The first is a 2-bit selector that picks how far the SPI reference is divided down to the SPI bit-clock enable. The encoding is non-linear: the selector chooses one of four fixed ratios rather than a binary divide. The second is a timer option, which only matters in external mode. The bus-rate enable feeds a further divide-by-10 that produces the UART reference.

Whenever the mode, the SPI selector or the timer option changes, every divider restarts from zero. The strobes that follow therefore arrive only after a complete period at the new settings.

Top module: `clk_strobe_gen`

## Requirements
- R1: While `rst_n` is low, every strobe is low. After `rst_n` rises, the counters hold for the first two rising edges. Counting starts on the third edge, with mode 0, selector 0 and timer option 0 as the starting settings.
- R2: In mode 0, `tmr_stb` fires once every 144 core cycles, `pwm_stb` once every 768 and `spi_ref_stb` once every 576.
- R3: In mode 1, `spi_ref_stb` fires once every 96 core cycles and `pwm_stb` once every 128.
- R4: In mode 1, `tmr_stb` fires once every 26 core cycles when the timer option (`ctrl_wdata` bit 4) is 1, and once every 24 cycles when it is 0.
- R5: `spi_bit_stb` fires on one `spi_ref_stb` out of N. N is set by the selector in `ctrl_wdata` bits 17:16: value 0 gives 32, 1 gives 8, 2 gives 2 and 3 gives 1.
- R6: `bus_stb` fires every second core cycle in mode 0. In mode 1 it is high on every cycle.
- R7: `uart_stb` fires on one `bus_stb` out of 10.
- R8: A cycle in which `ext_mode` differs from the mode in use, or a write changes the selector or the timer option, clears every counter. In that cycle all strobes are low, and each strobe next fires after one full period at the new settings.
- R9: Every strobe whose period exceeds one cycle is high for exactly one core cycle per period.
- R10: A control write that leaves bits 17:16 and bit 4 unchanged has no effect on any strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ext_mode | input | 1 | 0: core clock taken as the PLL-derived CPU clock; 1: core clock taken as the fixed external clock |
| ctrl_we | input | 1 | Control register write enable |
| ctrl_wdata | input | 32 | Control write data; bits 17:16 are the SPI selector, bit 4 is the timer option |
| bus_stb | output | 1 | Bus-rate enable |
| tmr_stb | output | 1 | Timer reference enable |
| pwm_stb | output | 1 | PWM reference enable |
| spi_ref_stb | output | 1 | SPI reference enable |
| spi_bit_stb | output | 1 | SPI bit-clock enable |
| uart_stb | output | 1 | UART reference enable |

## Verification
A counter that goes wrong inside a divider shows up at the ports as a strobe that fires too early or too late. The error is visible no later than the end of the affected period: at most 768 cycles for the top-level references. Because the SPI bit stage and the UART stage count upstream strobes, a fault there can take up to 32 SPI reference periods to appear. For that reason the bench runs long enough to cover several of those slow periods. A stale mode or option register shows up as the wrong ratio, or as a missing restart, from the first period after the change.

// File: rtl/clk_strobe_pkg.sv
package clk_strobe_pkg;

  // Bits needed to hold values 0 .. v-1 (at least one bit)
  function automatic int unsigned cnt_bits(input int unsigned v);
    return (v < 3) ? 1 : $clog2(v);
  endfunction

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  localparam int unsigned SPI_BIT_W = 6;

  // Non-linear selector decode for the SPI bit-clock stage
  function automatic logic [SPI_BIT_W-1:0] spi_bit_ratio(input logic [1:0] sel);
    logic [SPI_BIT_W-1:0] r;
    unique case (sel)
      2'd0:    r = 6'd32;
      2'd1:    r = 6'd8;
      2'd2:    r = 6'd2;
      default: r = 6'd1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/clk_strobe_rst_sync.sv
module clk_strobe_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_s_n = hold_q;
endmodule

// File: rtl/clk_strobe_div.sv
module clk_strobe_div #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en_in,
  input  logic [W-1:0] ratio,
  output logic         stb
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         last;

  // >= keeps a counter that is out of range from running away
  assign last = (cnt_q >= (ratio - W'(1)));
  assign stb  = en_in & ~clr & last;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)        cnt_d = '0;
    else if (en_in) cnt_d = last ? '0 : (cnt_q + W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/clk_strobe_gen.sv
module clk_strobe_gen
  import clk_strobe_pkg::*;
#(
  parameter int unsigned CTRL_W    = 32,
  parameter int unsigned SEL_LSB   = 16,
  parameter int unsigned OPT_BIT   = 4,
  parameter int unsigned PLL_BUS   = 2,
  parameter int unsigned EXT_BUS   = 1,
  parameter int unsigned UART_DIV  = 10,
  parameter int unsigned PLL_TMR   = 144,
  parameter int unsigned EXT_TMR_0 = 24,
  parameter int unsigned EXT_TMR_1 = 26,
  parameter int unsigned PLL_PWM   = 768,
  parameter int unsigned EXT_PWM   = 128,
  parameter int unsigned PLL_SPI   = 576,
  parameter int unsigned EXT_SPI   = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_mode,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic              bus_stb,
  output logic              tmr_stb,
  output logic              pwm_stb,
  output logic              spi_ref_stb,
  output logic              spi_bit_stb,
  output logic              uart_stb
);
  localparam int unsigned BUS_W  = cnt_bits(max_of(PLL_BUS, EXT_BUS)) + 1;
  localparam int unsigned UART_W = cnt_bits(UART_DIV) + 1;
  localparam int unsigned TMR_W  = cnt_bits(max_of(PLL_TMR, max_of(EXT_TMR_0, EXT_TMR_1))) + 1;
  localparam int unsigned PWM_W  = cnt_bits(max_of(PLL_PWM, EXT_PWM)) + 1;
  localparam int unsigned SPI_W  = cnt_bits(max_of(PLL_SPI, EXT_SPI)) + 1;

  logic       rst_s_n;
  logic       mode_q, mode_d;
  logic [1:0] sel_q, sel_d;
  logic       opt_q, opt_d;
  logic       cfg_chg;
  logic       clr;

  logic [BUS_W-1:0]     bus_ratio;
  logic [UART_W-1:0]    uart_ratio;
  logic [TMR_W-1:0]     tmr_ratio;
  logic [PWM_W-1:0]     pwm_ratio;
  logic [SPI_W-1:0]     spi_ratio;
  logic [SPI_BIT_W-1:0] bit_ratio;

  clk_strobe_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  // Configuration next state and restart detection
  always_comb begin
    mode_d  = ext_mode;
    sel_d   = sel_q;
    opt_d   = opt_q;
    cfg_chg = 1'b0;
    if (ctrl_we) begin
      sel_d   = ctrl_wdata[SEL_LSB +: 2];
      opt_d   = ctrl_wdata[OPT_BIT];
      cfg_chg = (sel_d != sel_q) || (opt_d != opt_q);
    end
    clr = cfg_chg || (mode_d != mode_q);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      mode_q <= 1'b0;
      sel_q  <= 2'd0;
      opt_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      sel_q  <= sel_d;
      opt_q  <= opt_d;
    end
  end

  // Ratio selection per mode
  always_comb begin
    uart_ratio = UART_W'(UART_DIV);
    bit_ratio  = spi_bit_ratio(sel_q);
    if (mode_q) begin
      bus_ratio = BUS_W'(EXT_BUS);
      tmr_ratio = opt_q ? TMR_W'(EXT_TMR_1) : TMR_W'(EXT_TMR_0);
      pwm_ratio = PWM_W'(EXT_PWM);
      spi_ratio = SPI_W'(EXT_SPI);
    end else begin
      bus_ratio = BUS_W'(PLL_BUS);
      tmr_ratio = TMR_W'(PLL_TMR);
      pwm_ratio = PWM_W'(PLL_PWM);
      spi_ratio = SPI_W'(PLL_SPI);
    end
  end

  clk_strobe_div #(.W(BUS_W)) u_bus (
    .clk(clk), .rst_n(rst_s_n), .clr(clr), .en_in(1'b1),
    .ratio(bus_ratio), .stb(bus_stb));

  clk_strobe_div #(.W(UART_W)) u_uart (
    .clk(clk), .rst_n(rst_s_n), .clr(clr), .en_in(bus_stb),
    .ratio(uart_ratio), .stb(uart_stb));

  clk_strobe_div #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_s_n), .clr(clr), .en_in(1'b1),
    .ratio(tmr_ratio), .stb(tmr_stb));

  clk_strobe_div #(.W(PWM_W)) u_pwm (
    .clk(clk), .rst_n(rst_s_n), .clr(clr), .en_in(1'b1),
    .ratio(pwm_ratio), .stb(pwm_stb));

  clk_strobe_div #(.W(SPI_W)) u_spi (
    .clk(clk), .rst_n(rst_s_n), .clr(clr), .en_in(1'b1),
    .ratio(spi_ratio), .stb(spi_ref_stb));

  clk_strobe_div #(.W(SPI_BIT_W)) u_spi_bit (
    .clk(clk), .rst_n(rst_s_n), .clr(clr), .en_in(spi_ref_stb),
    .ratio(bit_ratio), .stb(spi_bit_stb));

endmodule

// File: rtl/clk_strobe_gen_chk.sv
module clk_strobe_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic rst_s_n,
  input logic mode_q,
  input logic clr,
  input logic bus_stb,
  input logic tmr_stb,
  input logic pwm_stb,
  input logic spi_ref_stb,
  input logic spi_bit_stb,
  input logic uart_stb
);
  // R1: strobes stay low until the synchronised reset has released
  p_quiet_in_reset_r1: assert property (@(posedge clk)
    !rst_s_n |-> !(bus_stb || tmr_stb || pwm_stb || spi_ref_stb || spi_bit_stb || uart_stb));

  p_bit_needs_ref_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    spi_bit_stb |-> spi_ref_stb);

  p_bus_cont_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode_q && !clr) |-> bus_stb);

  p_uart_needs_bus_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    uart_stb |-> bus_stb);

  p_restart_quiet_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    clr |-> !(bus_stb || tmr_stb || pwm_stb || spi_ref_stb || spi_bit_stb || uart_stb));

  p_bus_gap_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!mode_q && bus_stb) |=> !bus_stb);

  p_tmr_gap_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    tmr_stb |=> !tmr_stb);

  p_pwm_gap_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    pwm_stb |=> !pwm_stb);
endmodule

bind clk_strobe_gen clk_strobe_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n), .mode_q(mode_q), .clr(clr),
  .bus_stb(bus_stb), .tmr_stb(tmr_stb), .pwm_stb(pwm_stb),
  .spi_ref_stb(spi_ref_stb), .spi_bit_stb(spi_bit_stb), .uart_stb(uart_stb));

// File: tb/clk_strobe_gen_bench.sv
module clk_strobe_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_mode = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [31:0] ctrl_wdata = 32'd0;
  logic bus_stb, tmr_stb, pwm_stb, spi_ref_stb, spi_bit_stb, uart_stb;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_strobe_gen u_clk_strobe_gen (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .ctrl_we(ctrl_we),
    .ctrl_wdata(ctrl_wdata), .bus_stb(bus_stb), .tmr_stb(tmr_stb),
    .pwm_stb(pwm_stb), .spi_ref_stb(spi_ref_stb), .spi_bit_stb(spi_bit_stb),
    .uart_stb(uart_stb));

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  // Stimulus values applied by tick()
  bit        rst_v = 1'b0;
  bit        mode_v = 1'b0;
  bit        we_v = 1'b0;
  bit [31:0] wd_v = 32'd0;
  string     tag = "R1";

  // Behavioural model state: configuration and elapsed counts since the last period
  int m_mode = 0, m_sel = 0, m_opt = 0;
  int n_bus = 0, n_uart = 0, n_tmr = 0, n_pwm = 0, n_spi = 0, n_bit = 0;
  int hold = 2;
  bit last_tmr = 1'b0;

  function automatic int bit_div(input int s);
    case (s)
      0: return 32;
      1: return 8;
      2: return 2;
      default: return 1;
    endcase
  endfunction

  task automatic cmp(input string name, input bit got, input bit exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s [%s] t=%0t got %0b expected %0b", name, tag, $time, got, exp);
    end
  endtask

  task automatic tick();
    bit restart;
    int p_bus, p_tmr, p_pwm, p_spi, p_bit;
    bit e_bus, e_uart, e_tmr, e_pwm, e_spi, e_bit;
    @(negedge clk);
    rst_n = rst_v; ext_mode = mode_v; ctrl_we = we_v; ctrl_wdata = wd_v;
    #1;
    p_bus = m_mode ? 1 : 2;
    p_tmr = m_mode ? (m_opt ? 26 : 24) : 144;
    p_pwm = m_mode ? 128 : 768;
    p_spi = m_mode ? 96 : 576;
    p_bit = bit_div(m_sel);
    restart = rst_v && hold == 0 &&
              ((int'(mode_v) != m_mode) ||
               (we_v && (int'(wd_v[17:16]) != m_sel || int'(wd_v[4]) != m_opt)));
    e_bus  = !restart && (n_bus + 1 == p_bus);
    e_uart = e_bus && (n_uart + 1 == 10);
    e_tmr  = !restart && (n_tmr + 1 == p_tmr);
    e_pwm  = !restart && (n_pwm + 1 == p_pwm);
    e_spi  = !restart && (n_spi + 1 == p_spi);
    e_bit  = e_spi && (n_bit + 1 == p_bit);
    if (!rst_v || hold > 0) begin
      e_bus = 0; e_uart = 0; e_tmr = 0; e_pwm = 0; e_spi = 0; e_bit = 0;
    end
    cmp("bus_stb R6", bus_stb, e_bus);
    cmp("uart_stb R7", uart_stb, e_uart);
    cmp("tmr_stb R2/R4", tmr_stb, e_tmr);
    cmp("pwm_stb R2/R3", pwm_stb, e_pwm);
    cmp("spi_ref_stb R2/R3", spi_ref_stb, e_spi);
    cmp("spi_bit_stb R5", spi_bit_stb, e_bit);
    last_tmr = tmr_stb;
    @(posedge clk);
    cycles++;
    if (!rst_v) begin
      hold = 2;
    end else if (hold > 0) begin
      hold--;
    end else if (restart) begin
      n_bus = 0; n_uart = 0; n_tmr = 0; n_pwm = 0; n_spi = 0; n_bit = 0;
      m_mode = int'(mode_v);
      if (we_v) begin m_sel = int'(wd_v[17:16]); m_opt = int'(wd_v[4]); end
    end else begin
      n_bus  = e_bus ? 0 : n_bus + 1;
      if (e_bus) n_uart = e_uart ? 0 : n_uart + 1;
      n_tmr  = e_tmr ? 0 : n_tmr + 1;
      n_pwm  = e_pwm ? 0 : n_pwm + 1;
      n_spi  = e_spi ? 0 : n_spi + 1;
      if (e_spi) n_bit = e_bit ? 0 : n_bit + 1;
      m_mode = int'(mode_v);
      if (we_v) begin m_sel = int'(wd_v[17:16]); m_opt = int'(wd_v[4]); end
    end
    we_v = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic write_ctrl(input int sel, input bit opt, input bit [31:0] other);
    wd_v = other;
    wd_v[17:16] = 2'(sel);
    wd_v[4] = opt;
    we_v = 1'b1;
    tick();
  endtask

  initial begin
    int gap;
    // R1: held in reset, then the two-edge release window
    tag = "R1";
    rst_v = 1'b0;
    run(5);
    rst_v = 1'b1;
    run(4);

    tag = "R2 R5 R6 R7 R9";
    run(19000);

    tag = "R8 R5";
    write_ctrl(1, 1'b0, 32'h0);
    run(5000);

    tag = "R10";
    write_ctrl(1, 1'b0, 32'hA5A0_00E3);
    run(1500);

    tag = "R3 R4 R6 R8";
    mode_v = 1'b1;
    run(3000);

    tag = "R4 R8";
    write_ctrl(1, 1'b1, 32'h0);
    run(1500);

    tag = "R5 sel2";
    write_ctrl(2, 1'b1, 32'h0);
    run(1000);
    tag = "R5 sel3";
    write_ctrl(3, 1'b1, 32'h0);
    run(1000);
    tag = "R5 sel0";
    write_ctrl(0, 1'b0, 32'h0);
    run(4000);

    // R8: back to mode 0, first timer strobe one full 144-cycle period after the restart cycle
    tag = "R8 first strobe";
    mode_v = 1'b0;
    tick();
    gap = 0;
    do begin
      tick();
      gap++;
    end while (!last_tmr && gap < 400);
    vectors++;
    if (gap != 144) begin
      errors++;
      $display("FAIL R8 first tmr_stb after restart at %0d cycles, expected 144", gap);
    end
    run(2000);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    while (cycles < MAX_CYCLES && !done) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule